// File: doc/BRIEF.md
# Frame-Synchronized Stereo Delay Line

This block delays a stereo audio stream by a whole number of audio frames. Each frame, the most recent left/right sample pair is written into an on-chip circular buffer. The pair that leaves the block is either the pair from a programmed number of frames earlier, or the current pair when that lane's delay is zero.

A host sets the delay of each lane through a small write port. Each lane has a pending register and an active register. Host writes only land in the pending register. The active register copies the pending value at the selected edge of the frame clock. That edge is the rising edge in standard format and the falling edge in I2S format. The output computed at the following frame edge is the first to use the new value. Every lane therefore changes its delay at one clean change point, and that point comes one frame after the setting is taken up.

The frame clock is assumed to be synchronous to `clk`, and each of its levels lasts at least one `clk` cycle. The buffer depth `DEPTH` must be a power of two.

Top module: `frame_sync_delay_line`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `out_vld`, `out_l` and `out_r` become 0 and both lane delays become 0.
- R2: A frame edge is a 0-to-1 change of `lrck` when `fmt_i2s`=0, or a 1-to-0 change when `fmt_i2s`=1. `out_vld` is 1 for exactly the cycle after the first `clk` edge that samples the new `lrck` level. A change of `lrck` in the other direction produces no pulse and leaves the outputs unchanged.
- R3: The pair written to the buffer at a frame edge is the last `smp_l`/`smp_r` pair accepted with `smp_vld`=1 in a cycle before that edge cycle.
- R4: Let a lane's active delay be d, with 1 ≤ d ≤ DEPTH. At frame edge n, the lane outputs the pair captured at edge n−d. Shrinking the delay therefore skips pairs, and growing it repeats older pairs.
- R5: With an active delay of 0, a lane outputs the pair captured for the same frame edge.
- R6: A host write is taken up at the first frame edge whose cycle follows the write, and it first affects the output at the frame edge after that. A write in the same cycle as a frame edge waits for the next edge.
- R7: When several writes to one address fall between two frame edges, only the last one takes effect.
- R8: Address 0 sets the left lane and address 1 sets the right lane, independently of each other. Writes to addresses 2 to 7 have no effect.
- R9: A written value larger than DEPTH acts as a delay of DEPTH.
- R10: A buffer position that has not been written since reset reads as 0. Output for edge n is 0 when d > n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lrck | input | 1 | Frame clock, synchronous to clk |
| fmt_i2s | input | 1 | 1 selects the falling frame edge, 0 selects the rising edge |
| smp_vld | input | 1 | Sample pair strobe |
| smp_l | input | SW | Left sample word |
| smp_r | input | SW | Right sample word |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Delay register address |
| host_data | input | 16 | Delay in frames |
| out_vld | output | 1 | One-cycle pulse after each frame edge |
| out_l | output | SW | Delayed left sample |
| out_r | output | SW | Delayed right sample |

## Verification
The hardest case to reach from the ports is a host write in the very cycle in which the frame clock reaches its edge level. That write must miss the current hand-over and wait a full frame. The stimulus reaches it by raising `host_we` on the same clock as the `lrck` change. It also pairs shrinking and growing delays with a history deeper than the buffer. Delays set early after reset, larger than the number of frames written so far, exercise the zero-fill path. Constrained random frames with random addresses, including the unused ones, then mix these cases under both edge polarities.

// File: rtl/dly_pkg.sv
// Package dly_pkg: constants shared by the delay line blocks.
// Assumes a two-lane (stereo) configuration with a 3-bit/16-bit host port.
package dly_pkg;
    localparam int NUM_LANES = 2;
    localparam int HAW       = 3;
    localparam int HDW       = 16;
    localparam int LANE_L    = 0;
    localparam int LANE_R    = 1;

    typedef enum logic {
        FMT_STD = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;
endpackage

// File: rtl/dly_frame_ctl.sv
// Module dly_frame_ctl: detects the selected frame clock edge and keeps the
// buffer write pointer and a saturating count of frames written since reset.
// Assumes lrck is synchronous to clk and DEPTH is a power of two.
module dly_frame_ctl #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lrck,
    input  logic          fmt_i2s,
    output logic          frame_edge,
    output logic [AW-1:0] wr_ptr,
    output logic [AW:0]   fill
);
    import dly_pkg::*;

    localparam logic [AW:0] FILL_MAX = (AW+1)'(DEPTH);

    logic lrck_d;

    // Remember the previous frame clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) lrck_d <= 1'b0;
        else        lrck_d <= lrck;
    end

    // Pick the edge polarity from the format select.
    always_comb begin
        if (fmt_e'(fmt_i2s) == FMT_I2S) frame_edge = lrck_d & ~lrck;
        else                            frame_edge = ~lrck_d & lrck;
    end

    // Advance the write pointer and the saturating fill count once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (frame_edge) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill != FILL_MAX) fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/dly_cfg_regs.sv
// Module dly_cfg_regs: per-lane pending and active delay registers.
// Host writes land in the pending register. The active register takes the
// clamped pending value at every frame edge. Unused addresses are ignored.
module dly_cfg_regs #(
    parameter int DEPTH = 1024,
    parameter int NL    = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [dly_pkg::HAW-1:0]     host_addr,
    input  logic [dly_pkg::HDW-1:0]     host_data,
    input  logic                        frame_edge,
    output logic [NL-1:0][AW:0]         act
);
    import dly_pkg::*;

    localparam logic [HDW-1:0] DEPTH_H = HDW'(DEPTH);
    localparam logic [AW:0]    DEPTH_D = (AW+1)'(DEPTH);

    logic [NL-1:0][HDW-1:0] pend;

    // Limit a host value to the buffer depth.
    function automatic logic [AW:0] clamp_dly(input logic [HDW-1:0] v);
        return (v > DEPTH_H) ? DEPTH_D : v[AW:0];
    endfunction

    // Stage host writes and hand them over at the frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            act  <= '0;
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (frame_edge) act[i] <= clamp_dly(pend[i]);
                if (host_we && host_addr == HAW'(i)) pend[i] <= host_data;
            end
        end
    end
endmodule

// File: rtl/dly_lane.sv
// Module dly_lane: one channel of the circular buffer. At each frame edge it
// stores the captured sample and presents the sample from 'act' frames ago.
// With act = 0 it bypasses the buffer, and positions not yet written read as 0.
module dly_lane #(
    parameter int DEPTH = 1024,
    parameter int SW    = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_edge,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW:0]   fill,
    input  logic [AW:0]   act,
    input  logic [SW-1:0] wdat,
    output logic [SW-1:0] dout
);
    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_idx;
    logic [SW-1:0] rd_dat;

    // Read position trails the write position by the active delay.
    always_comb begin
        rd_idx = wr_ptr - act[AW-1:0];
        rd_dat = mem[rd_idx];
    end

    // Store one sample per frame.
    always_ff @(posedge clk) begin
        if (frame_edge) mem[wr_ptr] <= wdat;
    end

    // Select bypass, zero-fill or buffered sample at the frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                dout <= '0;
        else if (frame_edge) begin
            if (act == '0)         dout <= wdat;
            else if (act > fill)   dout <= '0;
            else                   dout <= rd_dat;
        end
    end
endmodule

// File: rtl/frame_sync_delay_line.sv
// Module frame_sync_delay_line: stereo frame delay with host-programmed,
// frame-synchronized delay changes. Assumes lrck synchronous to clk, each
// lrck level held at least one clk cycle, and DEPTH a power of two.
module frame_sync_delay_line #(
    parameter int DEPTH = 1024,
    parameter int SW    = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lrck,
    input  logic                    fmt_i2s,
    input  logic                    smp_vld,
    input  logic [SW-1:0]           smp_l,
    input  logic [SW-1:0]           smp_r,
    input  logic                    host_we,
    input  logic [dly_pkg::HAW-1:0] host_addr,
    input  logic [dly_pkg::HDW-1:0] host_data,
    output logic                    out_vld,
    output logic [SW-1:0]           out_l,
    output logic [SW-1:0]           out_r
);
    import dly_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic                         frame_edge;
    logic [AW-1:0]                wr_ptr;
    logic [AW:0]                  fill;
    logic [NUM_LANES-1:0][AW:0]   act_vec;
    logic [SW-1:0]                cap_l, cap_r;
    logic [NUM_LANES-1:0][SW-1:0] lane_in, lane_out;

    dly_frame_ctl #(.DEPTH(DEPTH)) frame_i (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .fmt_i2s(fmt_i2s),
        .frame_edge(frame_edge), .wr_ptr(wr_ptr), .fill(fill)
    );

    dly_cfg_regs #(.DEPTH(DEPTH), .NL(NUM_LANES)) cfg_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_data(host_data), .frame_edge(frame_edge), .act(act_vec)
    );

    // Hold the latest sample pair offered by the deserializer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_l <= '0;
            cap_r <= '0;
        end else if (smp_vld) begin
            cap_l <= smp_l;
            cap_r <= smp_r;
        end
    end

    // Flag the frame whose outputs were just updated.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= frame_edge;
    end

    assign lane_in[LANE_L] = cap_l;
    assign lane_in[LANE_R] = cap_r;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dly_lane #(.DEPTH(DEPTH), .SW(SW)) lane_i (
            .clk(clk), .rst_n(rst_n), .frame_edge(frame_edge),
            .wr_ptr(wr_ptr), .fill(fill), .act(act_vec[g]),
            .wdat(lane_in[g]), .dout(lane_out[g])
        );
    end

    assign out_l = lane_out[LANE_L];
    assign out_r = lane_out[LANE_R];
endmodule

// File: rtl/dly_line_chk.sv
// Module dly_line_chk: protocol checks for frame_sync_delay_line, bound to
// the top module. Assumes the same DEPTH and SW as the checked instance.
module dly_line_chk #(
    parameter int DEPTH = 1024,
    parameter int SW    = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_edge,
    input logic          out_vld,
    input logic [SW-1:0] out_l,
    input logic [SW-1:0] out_r,
    input logic [AW:0]   act_l,
    input logic [AW:0]   act_r,
    input logic [SW-1:0] cap_l,
    input logic [SW-1:0] cap_r
);
    localparam logic [AW:0] DEPTH_D = (AW+1)'(DEPTH);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_l == '0 && out_r == '0 &&
                    act_l == '0 && act_r == '0));

    assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_edge |=> ($stable(out_l) && $stable(out_r)));

    assert_pulse_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> out_vld);

    assert_active_on_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_edge |=> ($stable(act_l) && $stable(act_r)));

    assert_bypass_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && act_l == '0) |=> (out_l == $past(cap_l)));

    assert_bypass_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && act_r == '0) |=> (out_r == $past(cap_r)));

    assert_delay_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_l <= DEPTH_D && act_r <= DEPTH_D));
endmodule

bind frame_sync_delay_line dly_line_chk #(.DEPTH(DEPTH), .SW(SW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_edge(frame_edge), .out_vld(out_vld),
    .out_l(out_l), .out_r(out_r), .act_l(act_vec[0]), .act_r(act_vec[1]),
    .cap_l(cap_l), .cap_r(cap_r)
);

// File: tb/frame_sync_delay_line_tb_top.sv
`timescale 1ns/1ps
module frame_sync_delay_line_tb_top;
    localparam int TB_DEPTH = 16;
    localparam int TB_SW    = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lrck = 1'b0;
    logic              fmt_i2s = 1'b0;
    logic              smp_vld = 1'b0;
    logic [TB_SW-1:0]  smp_l = '0, smp_r = '0;
    logic              host_we = 1'b0;
    logic [2:0]        host_addr = '0;
    logic [15:0]       host_data = '0;
    logic              out_vld;
    logic [TB_SW-1:0]  out_l, out_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int               n = 0;
    int               act_m [2];
    int               pend_m [2];
    logic [TB_SW-1:0] cap_lm = '0, cap_rm = '0;
    logic [TB_SW-1:0] hist_l [0:511];
    logic [TB_SW-1:0] hist_r [0:511];

    always #2.5 clk = ~clk;

    frame_sync_delay_line #(.DEPTH(TB_DEPTH), .SW(TB_SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .fmt_i2s(fmt_i2s),
        .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int clamp_m(input int v);
        return (v > TB_DEPTH) ? TB_DEPTH : v;
    endfunction

    function automatic logic [TB_SW-1:0] exp_out(input int ln);
        int d;
        d = act_m[ln];
        if (d == 0) return (ln == 0) ? cap_lm : cap_rm;
        if (d > n)  return '0;
        return (ln == 0) ? hist_l[n-d] : hist_r[n-d];
    endfunction

    // Host write between frame edges; the model stages it immediately.
    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
        if (a < 3'd2) pend_m[a] = d;
    endtask

    // One frame: non-edge level change, sample(s), edge, then output check.
    task automatic run_frame(input string tag, input bit dbl, input bit ew,
                             input logic [2:0] ea, input logic [15:0] ed);
        logic [TB_SW-1:0] el, er;
        @(negedge clk);
        lrck = fmt_i2s;
        @(negedge clk);
        chk("R2 no pulse on other-direction change", {31'd0, out_vld}, 32'd0);
        smp_vld = 1'b1; smp_l = TB_SW'($urandom); smp_r = TB_SW'($urandom);
        cap_lm = smp_l; cap_rm = smp_r;
        if (dbl) begin
            @(negedge clk);
            smp_l = TB_SW'($urandom); smp_r = TB_SW'($urandom);
            cap_lm = smp_l; cap_rm = smp_r;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        lrck = ~fmt_i2s;
        if (ew) begin host_we = 1'b1; host_addr = ea; host_data = ed; end
        @(negedge clk);
        host_we = 1'b0;
        el = exp_out(0);
        er = exp_out(1);
        chk("R2 out_vld pulse", {31'd0, out_vld}, 32'd1);
        chk({"R3 left ", tag}, 32'(out_l), 32'(el));
        chk({"R3 right ", tag}, 32'(out_r), 32'(er));
        hist_l[n] = cap_lm;
        hist_r[n] = cap_rm;
        n++;
        for (int i = 0; i < 2; i++) act_m[i] = clamp_m(pend_m[i]);
        if (ew && ea < 3'd2) pend_m[ea] = ed;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin act_m[i] = 0; pend_m[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 out_vld in reset", {31'd0, out_vld}, 32'd0);
        chk("R1 out_l in reset", 32'(out_l), 32'd0);
        chk("R1 out_r in reset", 32'(out_r), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 3; i++) run_frame("R5 bypass after reset", 1'b0, 1'b0, 3'd0, 16'd0);

        host_write(3'd0, 16'd5);
        host_write(3'd1, 16'd3);
        run_frame("R6 still old delay", 1'b0, 1'b0, 3'd0, 16'd0);
        for (int i = 0; i < 8; i++) run_frame("R4 R10 early delay", 1'b0, 1'b0, 3'd0, 16'd0);

        host_write(3'd0, 16'd2);
        host_write(3'd0, 16'd7);
        for (int i = 0; i < 3; i++) run_frame("R7 last write wins", 1'b1, 1'b0, 3'd0, 16'd0);

        host_write(3'd4, 16'd1);
        host_write(3'd7, 16'd0);
        for (int i = 0; i < 3; i++) run_frame("R8 unused address", 1'b0, 1'b0, 3'd0, 16'd0);

        host_write(3'd1, 16'd1000);
        for (int i = 0; i < 20; i++) run_frame("R9 clamp to depth", 1'b0, 1'b0, 3'd0, 16'd0);

        run_frame("R6 write on edge", 1'b0, 1'b1, 3'd0, 16'd1);
        for (int i = 0; i < 3; i++) run_frame("R6 write on edge", 1'b0, 1'b0, 3'd0, 16'd0);

        @(negedge clk) fmt_i2s = 1'b1;
        host_write(3'd0, 16'd12);
        for (int i = 0; i < 5; i++) run_frame("R4 grow in I2S", 1'b0, 1'b0, 3'd0, 16'd0);
        host_write(3'd1, 16'd2);
        for (int i = 0; i < 4; i++) run_frame("R4 shrink in I2S", 1'b0, 1'b0, 3'd0, 16'd0);
        host_write(3'd0, 16'd0);
        for (int i = 0; i < 3; i++) run_frame("R5 cancel", 1'b0, 1'b0, 3'd0, 16'd0);

        @(negedge clk) fmt_i2s = 1'b0;
        for (int i = 0; i < 150; i++) begin
            int nw;
            nw = $urandom_range(0, 3);
            for (int k = 0; k < nw; k++) begin
                logic [15:0] v;
                v = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 20));
                host_write(3'($urandom_range(0, 7)), v);
            end
            if (i == 75) begin @(negedge clk) fmt_i2s = 1'b1; end
            run_frame("R4 R7 R8 random", ($urandom_range(0, 3) == 0),
                      ($urandom_range(0, 7) == 0), 3'($urandom_range(0, 2)),
                      16'($urandom_range(0, 18)));
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule